// File: doc/BRIEF.md
# Sector Hamming ECC Checker-Corrector

This block closes the loop on single-error-correcting protection for one data sector. The flash interface delivers the sector's accumulated parity as two 12-bit halves. The block forms the 24-bit code that belongs with that sector. It compares that code with the 3-byte code read back alongside the sector, and sorts the outcome into one of four classes: clean, one flipped data bit, damage confined to the stored code, or beyond repair.

When one data bit is at fault, the block reports the byte index and bit position. It then repairs the sector buffer itself through a byte-wide port. The port reads the affected byte, XORs in a one-hot mask and writes the byte back. A single-cycle done pulse closes every check. A new check is accepted only while the block is idle.

Top module: `sector_ecc_fix`

## Requirements
- R1: One cycle after an accepted start, `calc_code_o` equals the bitwise inverse of {`par_hi_i`, `par_lo_i`}. The high half sits in bits 23:12. Byte 0 of the code (stored first) is bits 7:0.
- R2: If the calculated code equals `stored_code_i` (both little-endian, byte 0 in bits 7:0), `status_o` becomes 00 and `done_o` pulses one cycle after start.
- R3: Take d as the calculated code XOR the stored code. If d[11:0] XOR d[23:12] is all ones and d[23:15] < SECTOR_BYTES, then `status_o` becomes 01, `err_byte_o` becomes d[23:15] and `err_bit_o` becomes d[14:12].
- R4: For status 01, the block reads the byte at `err_byte_o` one cycle after start. It writes back read data XOR (1 << `err_bit_o`) three cycles after start. `done_o` pulses four cycles after start.
- R5: If the complement test of R3 holds but d[23:15] >= SECTOR_BYTES, `status_o` becomes 11 and the buffer port stays idle.
- R6: If d has exactly one bit set, `status_o` becomes 10, `done_o` pulses one cycle after start and the buffer port stays idle.
- R7: Any other nonzero d gives `status_o` 11 with `done_o` one cycle after start.
- R8: A start that arrives while a correction is in progress has no effect on status, code, buffer traffic or done timing.
- R9: `done_o` is a one-cycle pulse. After reset, `status_o` is 00, `done_o`, `buf_re_o` and `buf_we_o` are 0, and `calc_code_o` is 24'hFFFFFF. For status values other than 01, `err_byte_o` and `err_bit_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a check, taken only when idle |
| par_lo_i | input | 12 | Low parity half |
| par_hi_i | input | 12 | High parity half |
| stored_code_i | input | 24 | Code read with the sector, byte 0 in bits 7:0 |
| calc_code_o | output | 24 | Code to store for this sector |
| status_o | output | 2 | 00 clean, 01 data fixed, 10 code only, 11 uncorrectable |
| err_byte_o | output | 9 | Index of the corrected byte |
| err_bit_o | output | 3 | Bit position in that byte |
| done_o | output | 1 | One-cycle completion pulse |
| buf_addr_o | output | 9 | Sector buffer byte address |
| buf_re_o | output | 1 | Buffer read strobe, data returned next cycle |
| buf_rdata_i | input | 8 | Buffer read data |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Buffer write data |

## Verification
The code is due one cycle after start, and so are status and done for every case other than a data fix. On a data fix, the read strobe is due one cycle after start, the write three cycles after and done four cycles after. The bench drives start on a falling edge and counts falling edges until done. It compares that count with 1 or 4, and samples the strobes at the falling edge that follows each rising edge. The buffer model answers reads one cycle later. After each case, the model's content is compared with the expected flipped or untouched byte.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  localparam int HALF_W = 12;
  localparam int CODE_W = 2 * HALF_W;
  localparam int BIT_W  = 3;
  localparam int IDX_W  = HALF_W - BIT_W;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'b00,
    ST_DATA   = 2'b01,
    ST_CODE   = 2'b10,
    ST_UNCORR = 2'b11
  } ecc_status_e;
endpackage

// File: rtl/hecc_codegen.sv
module hecc_codegen
  import hecc_pkg::*;
(
  input  logic [HALF_W-1:0] lo_i,
  input  logic [HALF_W-1:0] hi_i,
  output logic [CODE_W-1:0] code_o
);
  // stored form is inverted so an erased (all ones) sector yields a zero parity match
  assign code_o = ~{hi_i, lo_i};
endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic [CODE_W-1:0] calc_i,
  input  logic [CODE_W-1:0] stored_i,
  output ecc_status_e       status_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BIT_W-1:0]  bit_o
);
  logic [CODE_W-1:0] diff;
  logic              compl_halves;
  logic              idx_ok;

  assign diff         = calc_i ^ stored_i;
  assign compl_halves = &(diff[HALF_W-1:0] ^ diff[CODE_W-1:HALF_W]);
  assign idx_o        = diff[CODE_W-1:HALF_W+BIT_W];
  assign bit_o        = diff[HALF_W+BIT_W-1:HALF_W];
  assign idx_ok       = 32'(idx_o) < SECTOR_BYTES;

  always_comb begin
    if (diff == '0)          status_o = ST_CLEAN;
    else if (compl_halves)   status_o = idx_ok ? ST_DATA : ST_UNCORR;
    else if ($onehot(diff))  status_o = ST_CODE;
    else                     status_o = ST_UNCORR;
  end
endmodule

// File: rtl/hecc_fixer.sv
module hecc_fixer
  import hecc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  output logic             idle_o,
  input  ecc_status_e      cls_status_i,
  input  logic [IDX_W-1:0] cls_idx_i,
  input  logic [BIT_W-1:0] cls_bit_i,
  output logic [1:0]       status_o,
  output logic [IDX_W-1:0] err_byte_o,
  output logic [BIT_W-1:0] err_bit_o,
  output logic             done_o,
  output logic [IDX_W-1:0] buf_addr_o,
  output logic             buf_re_o,
  input  logic [7:0]       buf_rdata_i,
  output logic             buf_we_o,
  output logic [7:0]       buf_wdata_o
);
  typedef enum logic [2:0] {S_IDLE, S_EVAL, S_RWAIT, S_MOD, S_FIN} fix_state_e;
  fix_state_e state_q;
  logic [7:0] mask_q;

  assign idle_o = (state_q == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      status_o    <= ST_CLEAN;
      err_byte_o  <= '0;
      err_bit_o   <= '0;
      done_o      <= 1'b0;
      buf_addr_o  <= '0;
      buf_re_o    <= 1'b0;
      buf_we_o    <= 1'b0;
      buf_wdata_o <= '0;
      mask_q      <= '0;
    end else begin
      done_o   <= 1'b0;
      buf_re_o <= 1'b0;
      buf_we_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept_i) state_q <= S_EVAL;
        S_EVAL: begin
          status_o <= cls_status_i;
          if (cls_status_i == ST_DATA) begin
            err_byte_o <= cls_idx_i;
            err_bit_o  <= cls_bit_i;
            buf_addr_o <= cls_idx_i;
            buf_re_o   <= 1'b1;
            mask_q     <= 8'(1) << cls_bit_i;
            state_q    <= S_RWAIT;
          end else begin
            err_byte_o <= '0;
            err_bit_o  <= '0;
            done_o     <= 1'b1;
            state_q    <= S_IDLE;
          end
        end
        S_RWAIT: state_q <= S_MOD;
        S_MOD: begin
          buf_we_o    <= 1'b1;
          buf_wdata_o <= buf_rdata_i ^ mask_q;
          state_q     <= S_FIN;
        end
        S_FIN: begin
          done_o  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4
  rw_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(buf_re_o && buf_we_o));
  // R4
  we_after_re_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> $past(buf_re_o, 2));
  // R5
  access_only_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_re_o || buf_we_o) |-> status_o == ST_DATA);
  // R4
  data_done_after_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == ST_DATA) |-> $past(buf_we_o));
endmodule

// File: rtl/sector_ecc_fix.sv
module sector_ecc_fix
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [HALF_W-1:0] par_lo_i,
  input  logic [HALF_W-1:0] par_hi_i,
  input  logic [CODE_W-1:0] stored_code_i,
  output logic [CODE_W-1:0] calc_code_o,
  output logic [1:0]        status_o,
  output logic [IDX_W-1:0]  err_byte_o,
  output logic [BIT_W-1:0]  err_bit_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  buf_addr_o,
  output logic              buf_re_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              buf_we_o,
  output logic [7:0]        buf_wdata_o
);
  logic [HALF_W-1:0] lo_q, hi_q;
  logic [CODE_W-1:0] stored_q;
  logic              idle, accept;
  ecc_status_e       cls_status;
  logic [IDX_W-1:0]  cls_idx;
  logic [BIT_W-1:0]  cls_bit;

  assign accept = start_i && idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      hi_q     <= '0;
      stored_q <= '0;
    end else if (accept) begin
      lo_q     <= par_lo_i;
      hi_q     <= par_hi_i;
      stored_q <= stored_code_i;
    end
  end

  hecc_codegen u_gen (.lo_i(lo_q), .hi_i(hi_q), .code_o(calc_code_o));

  hecc_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .calc_i(calc_code_o), .stored_i(stored_q),
    .status_o(cls_status), .idx_o(cls_idx), .bit_o(cls_bit)
  );

  hecc_fixer u_fix (
    .clk_i, .rst_ni, .accept_i(accept), .idle_o(idle),
    .cls_status_i(cls_status), .cls_idx_i(cls_idx), .cls_bit_i(cls_bit),
    .status_o, .err_byte_o, .err_bit_o, .done_o,
    .buf_addr_o, .buf_re_o, .buf_rdata_i, .buf_we_o, .buf_wdata_o
  );

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !idle) |=> $stable(calc_code_o));
endmodule

// File: tb/sector_ecc_fix_test.sv
module sector_ecc_fix_test;
  localparam int SB = 400;
  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [11:0] lo = 0, hi = 0;
  logic [23:0] stored = 0;
  logic [23:0] calc;
  logic [1:0] status;
  logic [8:0] ebyte, baddr;
  logic [2:0] ebit;
  logic done, bre, bwe;
  logic [7:0] brdata = 0, bwdata;
  logic [7:0] mem [512];
  int n_chk = 0, n_fail = 0, n_we = 0;

  always #5 clk = ~clk;

  sector_ecc_fix #(.SECTOR_BYTES(SB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .par_lo_i(lo), .par_hi_i(hi),
    .stored_code_i(stored), .calc_code_o(calc), .status_o(status),
    .err_byte_o(ebyte), .err_bit_o(ebit), .done_o(done), .buf_addr_o(baddr),
    .buf_re_o(bre), .buf_rdata_i(brdata), .buf_we_o(bwe), .buf_wdata_o(bwdata)
  );

  always @(posedge clk) begin
    if (bre) brdata <= mem[baddr];
    if (bwe) begin mem[baddr] <= bwdata; n_we <= n_we + 1; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // returns falling edges from start capture to done
  task automatic run(input logic [11:0] l, input logic [11:0] h, input logic [23:0] d,
                     output int lat);
    @(negedge clk);
    lo = l; hi = h; stored = ~{h, l} ^ d; start = 1;
    @(negedge clk);
    start = 0;
    lat = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (done) begin lat = i; break; end
    end
  endtask

  task automatic t_nofix(input string req, input logic [11:0] l, input logic [11:0] h,
                         input logic [23:0] d, input logic [1:0] exp_st);
    int lat, we0;
    we0 = n_we;
    run(l, h, d, lat);
    chk(lat == 1, req, lat, 1);
    chk(status == exp_st, req, status, exp_st);
    chk(calc == ~{h, l}, "R1", calc, ~{h, l});
    chk(ebyte == 0 && ebit == 0, "R9", {ebyte, ebit}, 0);
    chk(n_we == we0, req, n_we - we0, 0);
  endtask

  task automatic t_fix(input string req, input logic [8:0] b, input logic [2:0] k,
                       input logic [11:0] l, input logic [11:0] h, input bit poke);
    logic [11:0] dh;
    logic [7:0] orig;
    int we0, d0;
    dh = {b, k};
    orig = mem[b];
    we0 = n_we;
    @(negedge clk);
    lo = l; hi = h; stored = ~{h, l} ^ {dh, ~dh}; start = 1;
    @(negedge clk);
    start = 0;
    chk(calc == ~{h, l}, "R1", calc, ~{h, l});
    @(negedge clk);
    chk(bre && baddr == b, "R4", {bre, baddr}, {1'b1, b});
    chk(status == 2'b01 && ebyte == b && ebit == k, "R3", {status, ebyte, ebit}, {2'b01, b, k});
    if (poke) begin
      lo = ~l; hi = ~h; stored = 0; start = 1;
    end
    @(negedge clk);
    start = 0;
    chk(!bre && !bwe && !done, "R4", {bre, bwe, done}, 0);
    @(negedge clk);
    chk(bwe && bwdata == (orig ^ (8'd1 << k)), "R4", {bwe, bwdata}, {1'b1, orig ^ (8'd1 << k)});
    chk(!done, "R4", done, 0);
    @(negedge clk);
    chk(done && !bwe, "R4", {done, bwe}, 2'b10);
    chk(mem[b] == (orig ^ (8'd1 << k)), req, mem[b], orig ^ (8'd1 << k));
    @(negedge clk);
    chk(!done, "R9", done, 0);
    d0 = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (done || bre) d0++; end
    chk(d0 == 0 && n_we == we0 + 1, poke ? "R8" : req, d0, 0);
    chk(calc == ~{h, l} && status == 2'b01, poke ? "R8" : req, calc, ~{h, l});
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(status == 0 && !done && !bre && !bwe, "R9", {status, done, bre, bwe}, 0);
    chk(calc == 24'hFFFFFF, "R9", calc, 24'hFFFFFF);
    rst_n = 1;
    t_nofix("R2", 12'h000, 12'h000, 24'h0, 2'b00);
    t_nofix("R2", 12'hA5C, 12'h3E1, 24'h0, 2'b00);
    t_nofix("R6", 12'h123, 12'h456, 24'h000001, 2'b10);
    t_nofix("R6", 12'h7F0, 12'h00F, 24'h800000, 2'b10);
    t_nofix("R7", 12'h111, 12'h222, 24'h000003, 2'b11);
    t_nofix("R7", 12'h111, 12'h222, 24'hF0F0F0, 2'b11);
    // index 400 fails the range test: R5
    t_nofix("R5", 12'h0AB, 12'h0CD, {9'd400, 3'd2, ~{9'd400, 3'd2}}, 2'b11);
    t_nofix("R5", 12'h0AB, 12'h0CD, {9'd511, 3'd7, ~{9'd511, 3'd7}}, 2'b11);
    t_fix("R3", 9'd5, 3'd3, 12'h321, 12'h654, 0);
    t_fix("R3", 9'd0, 3'd0, 12'hFFF, 12'hFFF, 0);
    t_fix("R3", 9'd399, 3'd7, 12'h0F0, 12'hF0F, 0);
    t_fix("R8", 9'd77, 3'd5, 12'h9AB, 12'h135, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule